// File: doc/BRIEF.md
# Two-Ratio Alternating Clock Divider

This block derives a slow clock, typically in the 32.768 kHz range, from a fast crystal reference clock. A single integer divide ratio rarely lands on such a target. The block therefore alternates between two integer ratios. It runs a burst of output periods at a first period length, then a burst at a second period length, and repeats forever. The average output frequency falls between the two ratios.

Configuration is presented as plain level inputs: two period fields, two repeat fields, a mode select, an input gate and an output gate. Every length field is coded as the wanted count minus one.

The block drives two outputs. One is a roughly half-duty divided clock level. The other is a one-cycle tick at the start of each output period, which serves as a clock enable. New settings are picked up only at a burst boundary or while the input gate is closed, so a running output never produces a truncated period. All pins are plain control and status signals. No stream interface is involved, and there is no back-pressure.

Top module: `dualmod_clkdiv`

## Requirements
- R1: With cfg_dual low, every output period lasts cfg_n1+1 reference cycles, and the values on cfg_n2, cfg_m1 and cfg_m2 have no effect on the output.
- R2: With cfg_dual high, the output gives cfg_m1+1 periods of cfg_n1+1 cycles each, then cfg_m2+1 periods of cfg_n2+1 cycles each, and this pattern repeats indefinitely.
- R3: Every length field is coded as the count minus one. A period field of 0 gives a one-cycle period, and a repeat field of 0 gives a burst of a single period.
- R4: In each period of P cycles, tick_out is high only in the first cycle, and clk_out is high in the first (P+1)/2 cycles (integer division) and low in the rest.
- R5: While in_en is low, both outputs are low from the next cycle on, all counters clear and the burst pointer returns to the first ratio. After in_en is sampled high, the first tick appears one cycle later and starts a first-ratio burst.
- R6: While out_en is low, both outputs are low in the same cycle, but counting goes on, so the tick grid is unchanged when out_en returns high.
- R7: Configuration is captured only while in_en is low, at the first enabled cycle, or at the end of a burst (in single mode, at the end of every period). A change made in the middle of a burst leaves that burst's periods unchanged.
- R8: A low rst_n, sampled on a clock edge, clears all counters, selects the first ratio and drives both outputs low. After rst_n is released, running resumes as described in R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_dual | input | 1 | 1 = alternate two ratios, 0 = first ratio only |
| cfg_n1 | input | CNT_W | First period length minus one |
| cfg_n2 | input | CNT_W | Second period length minus one |
| cfg_m1 | input | REP_W | First-ratio burst length minus one |
| cfg_m2 | input | REP_W | Second-ratio burst length minus one |
| in_en | input | 1 | Input gate; low stops and clears the counters |
| out_en | input | 1 | Output gate; low forces outputs low, counting continues |
| clk_out | output | 1 | Divided clock level |
| tick_out | output | 1 | One-cycle pulse at each period start |

## Verification
The assertions check the cycle-level rules on every cycle. These are: both gates forcing the outputs low, the divide counter staying within the active limit, the burst pointer and captured settings holding between boundaries, single mode never leaving the first ratio, and reset clearing the outputs. Some results can only be seen across many cycles, and only the bench scenarios can show them. These are the period lengths themselves, the order and count of periods in each burst, the duty pattern inside a period, the deferred take-up of a mid-burst change, and the tick grid staying in place across an output-gate gap.

// File: rtl/dualmod_pkg.sv
package dualmod_pkg;

  // Which of the two ratios drives the divide counter.
  typedef enum logic {
    PH_FIRST  = 1'b0,
    PH_SECOND = 1'b1
  } dm_phase_e;

endpackage

// File: rtl/dmd_cfg_shadow.sv
// Captured copy of the configuration; changes only when load is high.
module dmd_cfg_shadow #(
  parameter int CNT_W = 12,
  parameter int REP_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             d_dual,
  input  logic [CNT_W-1:0] d_n1,
  input  logic [CNT_W-1:0] d_n2,
  input  logic [REP_W-1:0] d_m1,
  input  logic [REP_W-1:0] d_m2,
  output logic             q_dual,
  output logic [CNT_W-1:0] q_n1,
  output logic [CNT_W-1:0] q_n2,
  output logic [REP_W-1:0] q_m1,
  output logic [REP_W-1:0] q_m2
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_dual <= 1'b0;
      q_n1   <= '0;
      q_n2   <= '0;
      q_m1   <= '0;
      q_m2   <= '0;
    end else if (load) begin
      q_dual <= d_dual;
      q_n1   <= d_n1;
      q_n2   <= d_n2;
      q_m1   <= d_m1;
      q_m2   <= d_m2;
    end
  end

endmodule

// File: rtl/dmd_period_ctr.sv
// Counts reference cycles from 0 up to limit, then wraps.
module dmd_period_ctr #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);

  assign wrap = adv && (count == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      count <= '0;
    end else if (adv) begin
      count <= wrap ? '0 : count + CNT_W'(1);
    end
  end

endmodule

// File: rtl/dmd_phase_seq.sv
// Counts finished periods within a burst and flips between the two ratios.
module dmd_phase_seq
  import dualmod_pkg::*;
#(
  parameter int REP_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wrap,
  input  logic             cur_dual,
  input  logic             next_dual,
  input  logic [REP_W-1:0] m1,
  input  logic [REP_W-1:0] m2,
  output dm_phase_e        phase,
  output logic             boundary
);

  logic [REP_W-1:0] rep_cnt;
  logic [REP_W-1:0] rep_lim;
  logic             last_rep;

  assign rep_lim  = (phase == PH_SECOND) ? m2 : m1;
  assign last_rep = !cur_dual || (rep_cnt == rep_lim);
  assign boundary = wrap && last_rep;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      rep_cnt <= '0;
      phase   <= PH_FIRST;
    end else if (boundary) begin
      rep_cnt <= '0;
      if (next_dual) begin
        phase <= (phase == PH_FIRST) ? PH_SECOND : PH_FIRST;
      end else begin
        phase <= PH_FIRST;
      end
    end else if (wrap) begin
      rep_cnt <= rep_cnt + REP_W'(1);
    end
  end

endmodule

// File: rtl/dualmod_clkdiv.sv
module dualmod_clkdiv
  import dualmod_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int REP_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_dual,
  input  logic [CNT_W-1:0] cfg_n1,
  input  logic [CNT_W-1:0] cfg_n2,
  input  logic [REP_W-1:0] cfg_m1,
  input  logic [REP_W-1:0] cfg_m2,
  input  logic             in_en,
  input  logic             out_en,
  output logic             clk_out,
  output logic             tick_out
);

  localparam int HW   = CNT_W + 1;
  localparam int SH_W = 1 + 2 * CNT_W + 2 * REP_W;

  logic             run;
  logic             load;
  logic             adv;
  logic             wrap;
  logic             boundary;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] cur_n;
  logic [HW-1:0]    high_len;
  dm_phase_e        phase;

  logic             s_dual;
  logic [CNT_W-1:0] s_n1;
  logic [CNT_W-1:0] s_n2;
  logic [REP_W-1:0] s_m1;
  logic [REP_W-1:0] s_m2;
  logic [SH_W-1:0]  shadow_bus;

  // run goes high one edge after the input gate opens; that edge captures settings
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
    end else begin
      run <= in_en;
    end
  end

  assign adv  = run && in_en;
  assign load = !run || !in_en || boundary;

  dmd_cfg_shadow #(
    .CNT_W(CNT_W),
    .REP_W(REP_W)
  ) u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .d_dual (cfg_dual),
    .d_n1   (cfg_n1),
    .d_n2   (cfg_n2),
    .d_m1   (cfg_m1),
    .d_m2   (cfg_m2),
    .q_dual (s_dual),
    .q_n1   (s_n1),
    .q_n2   (s_n2),
    .q_m1   (s_m1),
    .q_m2   (s_m2)
  );

  assign shadow_bus = {s_dual, s_n1, s_n2, s_m1, s_m2};
  assign cur_n      = (phase == PH_SECOND) ? s_n2 : s_n1;

  dmd_period_ctr #(
    .CNT_W(CNT_W)
  ) u_period (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!in_en),
    .adv   (adv),
    .limit (cur_n),
    .count (count),
    .wrap  (wrap)
  );

  dmd_phase_seq #(
    .REP_W(REP_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (!in_en),
    .wrap      (wrap),
    .cur_dual  (s_dual),
    .next_dual (cfg_dual),
    .m1        (s_m1),
    .m2        (s_m2),
    .phase     (phase),
    .boundary  (boundary)
  );

  // high for ceil(P/2) cycles where P = cur_n + 1
  assign high_len = ({1'b0, cur_n} + HW'(2)) >> 1;
  assign clk_out  = run && out_en && ({1'b0, count} < high_len);
  assign tick_out = run && out_en && (count == '0);

endmodule

// File: rtl/dualmod_clkdiv_chk.sv
module dualmod_clkdiv_chk #(
  parameter int CNT_W = 12,
  parameter int REP_W = 12
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         in_en,
  input logic                         out_en,
  input logic                         clk_out,
  input logic                         tick_out,
  input logic                         run,
  input logic                         wrap,
  input logic                         boundary,
  input logic                         phase,
  input logic                         s_dual,
  input logic [CNT_W-1:0]             count,
  input logic [CNT_W-1:0]             cur_n,
  input logic [2*CNT_W+2*REP_W:0]     shadow_bus
);

  a_r1_single_first: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !s_dual) |-> (phase == 1'b0));

  a_r2_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_en && !wrap) |=> $stable(phase));

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (count <= cur_n));

  a_r4_tick_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |-> clk_out);

  a_r5_in_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !in_en |=> (!tick_out && !clk_out && count == '0 && phase == 1'b0));

  a_r6_out_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> (!tick_out && !clk_out));

  a_r7_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && in_en && !boundary) |=> $stable(shadow_bus));

  a_r8_reset: assert property (@(posedge clk)
    !rst_n |=> (!tick_out && !clk_out && count == '0 && phase == 1'b0));

endmodule

bind dualmod_clkdiv dualmod_clkdiv_chk #(
  .CNT_W(CNT_W),
  .REP_W(REP_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_en      (in_en),
  .out_en     (out_en),
  .clk_out    (clk_out),
  .tick_out   (tick_out),
  .run        (run),
  .wrap       (wrap),
  .boundary   (boundary),
  .phase      (phase),
  .s_dual     (s_dual),
  .count      (count),
  .cur_n      (cur_n),
  .shadow_bus (shadow_bus)
);

// File: tb/dualmod_clkdiv_test.sv
module dualmod_clkdiv_test;

  localparam int CW = 12;
  localparam int RW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_dual = 1'b0;
  logic [CW-1:0] cfg_n1 = '0;
  logic [CW-1:0] cfg_n2 = '0;
  logic [RW-1:0] cfg_m1 = '0;
  logic [RW-1:0] cfg_m2 = '0;
  logic          in_en = 1'b0;
  logic          out_en = 1'b0;
  logic          clk_out;
  logic          tick_out;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dualmod_clkdiv #(.CNT_W(CW), .REP_W(RW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual), .cfg_n1(cfg_n1),
    .cfg_n2(cfg_n2), .cfg_m1(cfg_m1), .cfg_m2(cfg_m2), .in_en(in_en),
    .out_en(out_en), .clk_out(clk_out), .tick_out(tick_out)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // cycles from the current negedge to the next negedge that shows a tick
  task automatic next_gap(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!tick_out && gap < 1000);
  endtask

  task automatic expect_gaps(input string req, input int exp[]);
    int g;
    foreach (exp[i]) begin
      next_gap(g);
      chk(req, $sformatf("period %0d", i), g, exp[i]);
    end
  endtask

  task automatic start(input logic d, input int n1, input int n2, input int m1, input int m2);
    int g;
    @(negedge clk);
    in_en = 1'b0; out_en = 1'b1;
    cfg_dual = d; cfg_n1 = CW'(n1); cfg_n2 = CW'(n2); cfg_m1 = RW'(m1); cfg_m2 = RW'(m2);
    @(negedge clk);
    in_en = 1'b1;
    next_gap(g);
    chk("R5", "first tick after enable", g, 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R8", "tick in reset", int'(tick_out), 0);
    chk("R8", "clk_out in reset", int'(clk_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", "tick after reset, gate closed", int'(tick_out), 0);
  endtask

  task automatic t_single();
    start(1'b0, 4, 9, 3, 7);
    expect_gaps("R1", '{5, 5, 5});
    for (int i = 0; i < 5; i++) begin
      chk("R4", $sformatf("clk_out cycle %0d", i), int'(clk_out), (i < 3) ? 1 : 0);
      chk("R4", $sformatf("tick cycle %0d", i), int'(tick_out), (i == 0) ? 1 : 0);
      @(negedge clk);
    end
    // other fields move; period must stay 5
    cfg_n2 = CW'(1); cfg_m1 = RW'(0); cfg_m2 = RW'(5);
    expect_gaps("R1", '{5, 5, 5});
  endtask

  task automatic t_dual();
    start(1'b1, 2, 4, 1, 2);
    expect_gaps("R2", '{3, 3, 5, 5, 5, 3, 3, 5, 5, 5});
  endtask

  task automatic t_minimum();
    start(1'b0, 0, 7, 7, 7);
    for (int i = 0; i < 4; i++) begin
      chk("R3", "one-cycle period tick", int'(tick_out), 1);
      chk("R3", "one-cycle period clk_out", int'(clk_out), 1);
      @(negedge clk);
    end
    start(1'b1, 0, 1, 0, 0);
    expect_gaps("R3", '{1, 2, 1, 2, 1, 2});
  endtask

  task automatic t_outgate();
    int g;
    start(1'b0, 4, 0, 0, 0);
    out_en = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk("R6", "tick while output gated", int'(tick_out), 0);
      chk("R6", "clk_out while output gated", int'(clk_out), 0);
    end
    out_en = 1'b1;
    next_gap(g);
    chk("R6", "grid kept across gate", g, 3);
    expect_gaps("R6", '{5});
  endtask

  task automatic t_ingate();
    int g;
    start(1'b1, 2, 4, 1, 2);
    expect_gaps("R5", '{3, 3, 5});
    in_en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R5", "tick while input gated", int'(tick_out), 0);
      chk("R5", "clk_out while input gated", int'(clk_out), 0);
    end
    in_en = 1'b1;
    next_gap(g);
    chk("R5", "restart tick", g, 1);
    expect_gaps("R5", '{3, 3, 5, 5, 5, 3});
  endtask

  task automatic t_reload();
    start(1'b0, 4, 0, 0, 0);
    repeat (2) @(negedge clk);
    cfg_n1 = CW'(6);
    expect_gaps("R7", '{3, 7, 7});
    start(1'b1, 2, 4, 1, 2);
    cfg_n1 = CW'(5);
    expect_gaps("R7", '{3, 3, 5, 5, 5, 6, 6, 5});
  endtask

  task automatic t_reset_mid();
    int g;
    start(1'b1, 2, 4, 1, 2);
    expect_gaps("R8", '{3, 3});
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8", "tick after mid-run reset", int'(tick_out), 0);
    chk("R8", "clk_out after mid-run reset", int'(clk_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
    next_gap(g);
    chk("R8", "first tick after reset release", g, 1);
    expect_gaps("R8", '{3, 3, 5});
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_dual();
    t_minimum();
    t_outgate();
    t_ingate();
    t_reload();
    t_reset_mid();
    summary();
    $finish;
  end

endmodule